// File: doc/BRIEF.md
# Shared-Port Memory Card Bank Selector

This block holds the bank-switching logic of one memory card on an 8-bit processor bus. All cards in a system listen to the same I/O bank-select port, or to the same aligned group of ports. Every write to that port is a broadcast. Each card splits the written value into an id field and a page field, and compares the id field with its strapped id. The card whose id matches becomes the selected card and latches the page field. Every other card drops its selection. Software therefore works with logical page numbers. Adding a card only needs a free id range and no software changes.

The selected card serves the upper 32 KiB memory window (addresses with A15 high) from its latched page. It drives the page onto the high address lines of its memory array. A read of the bank-select port is answered only by the selected card, which returns its current select value. An unselected card leaves the bus undriven.

In port-group mode, the low address bits of the port group are joined with the data byte to form a wider select word. A card built for the single-port scheme can also be set to treat those extra address bits as required zeros.

Top module: `bank_card_decoder`

## Requirements
- R1: An I/O write to a decoded bank-select port clears the selected flag on the next clock edge unless the id field of the select word equals the card's id. After a matching write, the flag is set.
- R2: The select word is split by the parameter PAGE_BITS. The low PAGE_BITS bits form the page field and the remaining upper bits form the id field. Default: 2-page card, with the id in D7..D1 and the page in D0. With PAGE_BITS=3, the id is in the bits above bit 2.
- R3: On a matching write, the page field is stored. `mem_addr` equals {stored page, addr[14:0]}.
- R4: `data_oe` is high only during an I/O read (iorq and rd) of a decoded port while the card is selected. `data_out` then carries the low 8 bits of {id field, stored page}.
- R5: `mem_en` is high exactly when mreq is high, addr[15] is high and the card is selected.
- R6: A default card with id 0000010 is selected on page 0 by writing 04h and on page 1 by writing 05h. Writing any other value, such as 06h or 03h, deselects it.
- R7: With GROUP_BITS=m, the select word is {addr[m-1:0], data_in}. Example: 16 ports at E0h with 8 pages and id 0A5h select page 3 on a write of 2Bh to port E5h. They select page 4 on a write of 2Ch to port E5h. A write of 2Bh to port E4h deselects.
- R8: With ADDR_ZERO set, the address part of the id must be zero and the upper GROUP_BITS bits of `card_id` are ignored.
- R9: A port is decoded when addr[IO_AW-1:GROUP_BITS] equals the same bits of PORT_BASE. A write to any other port leaves the selection and the page unchanged.
- R10: Reset leaves the card deselected with page 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iorq | input | 1 | I/O request |
| mreq | input | 1 | Memory request |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 16 | Bus address |
| data_in | input | 8 | Bus data into the card |
| card_id | input | ID_W | Strapped card id (ID_W = GROUP_BITS + 8 - PAGE_BITS) |
| data_out | output | 8 | Read-back value |
| data_oe | output | 1 | Drive enable for the external tri-state data buffer |
| mem_en | output | 1 | Memory array enable |
| mem_addr | output | PAGE_BITS+15 | Memory array address |

## Verification
The default card receives its own two page codes, the neighbouring codes just above and below its id range, and writes to an adjacent port. These separate an exact id compare from an off-by-one or a missing deselect, and show whether the port decode is too wide. An 8-page group card receives the same data byte on two ports of its group. This tells whether address bits enter the id compare, and a second data byte shows whether the page field is taken from the right bits. A card in zero-extension mode has nonzero strap bits above its data id. This shows whether those bits are truly ignored and whether a nonzero group address deselects it.

// File: rtl/bank_card_decoder.sv
module bank_card_decoder #(
  parameter int IO_AW = 8,
  parameter int GROUP_BITS = 0,
  parameter int PAGE_BITS = 1,
  parameter logic [IO_AW-1:0] PORT_BASE = 'hF0,
  parameter bit ADDR_ZERO = 1'b0,
  localparam int SEL_W = GROUP_BITS + 8,
  localparam int ID_W = SEL_W - PAGE_BITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   iorq,
  input  logic                   mreq,
  input  logic                   rd,
  input  logic                   wr,
  input  logic [15:0]            addr,
  input  logic [7:0]             data_in,
  input  logic [ID_W-1:0]        card_id,
  output logic [7:0]             data_out,
  output logic                   data_oe,
  output logic                   mem_en,
  output logic [PAGE_BITS+14:0]  mem_addr
);

  logic                 sel;
  logic [PAGE_BITS-1:0] page;
  logic [SEL_W-1:0]     word;
  logic [ID_W-1:0]      want_id;
  logic [SEL_W-1:0]     stored;
  logic                 port_hit, wr_hit, id_ok;

  assign port_hit = iorq && (addr[IO_AW-1:GROUP_BITS] == PORT_BASE[IO_AW-1:GROUP_BITS]);
  assign wr_hit   = port_hit && wr;

  generate
    if (GROUP_BITS > 0) begin : g_grp
      assign word = {addr[GROUP_BITS-1:0], data_in};
      if (ADDR_ZERO) begin : g_zero
        assign want_id = {{GROUP_BITS{1'b0}}, card_id[ID_W-GROUP_BITS-1:0]};
      end else begin : g_full
        assign want_id = card_id;
      end
    end else begin : g_single
      assign word    = data_in;
      assign want_id = card_id;
    end
  endgenerate

  assign id_ok = (word[SEL_W-1:PAGE_BITS] == want_id);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= 1'b0;
      page <= '0;
    end else if (wr_hit) begin
      sel <= id_ok;
      if (id_ok) page <= word[PAGE_BITS-1:0];
    end
  end

  assign stored   = {want_id, page};
  assign data_out = stored[7:0];
  assign data_oe  = port_hit && rd && sel;
  assign mem_en   = mreq && addr[15] && sel;
  assign mem_addr = {page, addr[14:0]};

  assert_wr_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !id_ok) |=> !sel);

  assert_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel) |-> $past(wr_hit));

  assert_wr_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && id_ok) |=> (sel && page == $past(word[PAGE_BITS-1:0])));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(sel) && $stable(page)));

endmodule

// File: tb/bank_card_decoder_tb_top.sv
module bank_card_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iorq = 0, mreq = 0, rd = 0, wr = 0;
  logic [15:0] addr = '0;
  logic [7:0]  data_in = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] d0_q, g_q, l_q;
  logic d0_oe, g_oe, l_oe, d0_me, g_me, l_me;
  logic [15:0] d0_ma, l_ma;
  logic [17:0] g_ma;

  bank_card_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .iorq(iorq), .mreq(mreq), .rd(rd), .wr(wr),
    .addr(addr), .data_in(data_in), .card_id(7'b0000010),
    .data_out(d0_q), .data_oe(d0_oe), .mem_en(d0_me), .mem_addr(d0_ma));

  bank_card_decoder #(.GROUP_BITS(4), .PAGE_BITS(3), .PORT_BASE(8'hE0)) grp_i (
    .clk(clk), .rst_n(rst_n), .iorq(iorq), .mreq(mreq), .rd(rd), .wr(wr),
    .addr(addr), .data_in(data_in), .card_id(9'h0A5),
    .data_out(g_q), .data_oe(g_oe), .mem_en(g_me), .mem_addr(g_ma));

  bank_card_decoder #(.GROUP_BITS(4), .PAGE_BITS(1), .PORT_BASE(8'hE0), .ADDR_ZERO(1'b1)) leg_i (
    .clk(clk), .rst_n(rst_n), .iorq(iorq), .mreq(mreq), .rd(rd), .wr(wr),
    .addr(addr), .data_in(data_in), .card_id(11'b1111_0000011),
    .data_out(l_q), .data_oe(l_oe), .mem_en(l_me), .mem_addr(l_ma));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [7:0] port, logic [7:0] d);
    @(negedge clk);
    addr = {8'h00, port}; data_in = d; iorq = 1; wr = 1;
    @(negedge clk);
    iorq = 0; wr = 0;
  endtask

  task automatic io_read(logic [7:0] port);
    @(negedge clk);
    addr = {8'h00, port}; iorq = 1; rd = 1;
    #1;
  endtask

  task automatic mem_rd(logic [15:0] a);
    @(negedge clk);
    addr = a; mreq = 1; rd = 1;
    #1;
  endtask

  task automatic bus_idle;
    iorq = 0; mreq = 0; rd = 0; wr = 0;
  endtask

  task automatic t_reset;
    mem_rd(16'h8000);
    check("R10 dut mem_en", d0_me, 0);
    check("R10 dut page0", d0_ma, 16'h0000);
    check("R10 grp mem_en", g_me, 0);
    check("R10 leg mem_en", l_me, 0);
    bus_idle();
    io_read(8'hF0);
    check("R10 dut oe", d0_oe, 0);
    bus_idle();
  endtask

  task automatic t_single;
    io_write(8'hF0, 8'h04);
    mem_rd(16'h8123);
    check("R6 04h selects", d0_me, 1);
    check("R3 page0 addr", d0_ma, 16'h0123);
    bus_idle();
    io_write(8'hF0, 8'h05);
    mem_rd(16'h8123);
    check("R6 05h selects", d0_me, 1);
    check("R3 page1 addr", d0_ma, 16'h8123);
    bus_idle();
    io_read(8'hF0);
    check("R4 read oe", d0_oe, 1);
    check("R4 read data", d0_q, 8'h05);
    bus_idle();
    mem_rd(16'h0123);
    check("R5 A15 low", d0_me, 0);
    bus_idle();
    io_write(8'hF1, 8'h00);
    mem_rd(16'h8001);
    check("R9 other port ignored sel", d0_me, 1);
    check("R9 other port ignored page", d0_ma, 16'h8001);
    bus_idle();
    io_read(8'hF1);
    check("R9 R4 other port no oe", d0_oe, 0);
    bus_idle();
    io_write(8'hF0, 8'h06);
    mem_rd(16'h8000);
    check("R6 R1 06h deselects", d0_me, 0);
    bus_idle();
    io_read(8'hF0);
    check("R4 unselected no oe", d0_oe, 0);
    bus_idle();
    io_write(8'hF0, 8'h04);
    io_write(8'hF0, 8'h03);
    mem_rd(16'h8000);
    check("R6 R1 03h deselects", d0_me, 0);
    bus_idle();
  endtask

  task automatic t_group;
    io_write(8'hE5, 8'h2B);
    mem_rd(16'hC001);
    check("R7 grp selects", g_me, 1);
    check("R2 R3 grp page3", g_ma, 18'h1C001);
    bus_idle();
    io_read(8'hE9);
    check("R4 grp oe", g_oe, 1);
    check("R4 grp data", g_q, 8'h2B);
    bus_idle();
    io_write(8'hE5, 8'h2C);
    mem_rd(16'h8000);
    check("R2 grp page4", g_ma, 18'h20000);
    bus_idle();
    io_write(8'hD5, 8'h00);
    mem_rd(16'h8000);
    check("R9 grp outside group", g_me, 1);
    bus_idle();
    io_write(8'hE4, 8'h2B);
    mem_rd(16'h8000);
    check("R7 R1 grp addr mismatch", g_me, 0);
    bus_idle();
  endtask

  task automatic t_legacy;
    io_write(8'hE0, 8'h07);
    mem_rd(16'h8000);
    check("R8 leg selects", l_me, 1);
    check("R8 leg page1", l_ma, 16'h8000);
    bus_idle();
    io_read(8'hE0);
    check("R8 leg read", l_q, 8'h07);
    bus_idle();
    io_write(8'hE1, 8'h07);
    mem_rd(16'h8000);
    check("R8 leg nonzero addr deselects", l_me, 0);
    bus_idle();
    io_write(8'hE0, 8'h06);
    mem_rd(16'h8000);
    check("R8 leg page0", l_me, 1);
    check("R8 leg page0 addr", l_ma, 16'h0000);
    bus_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single();
    t_group();
    t_legacy();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule